// File: doc/BRIEF.md
# Zero-overhead hardware loop sequencer

This block sits beside the program counter of a small instruction-fetch path and runs counted or condition-terminated loops without any branch instruction inside the loop body. A single setup command is given while the fetch stream is still before the loop. The command carries the first and last body addresses, an iteration count and a mode that picks how the loop ends. The block pushes that loop onto a small stack. On every fetch it then compares the fetch address with the last body address of the innermost loop. In the same cycle it selects the next fetch address: the loop start, the fall-through address, or a skip target.

Loops nest up to a fixed stack depth. Only the innermost loop is compared. When that loop exits, it is removed from the stack and the loop around it becomes the one that is compared. The iteration count and the end test live in the loop stack, so the wrap back to the loop start costs no cycle and leaves no hole in the fetch stream.

Top module: `zol_seq`

## Requirements
- R1: After reset the stack is empty: `loop_depth` is 0, `setup_reject` is low, and `next_pc` equals `fetch_pc`+1.
- R2: When `fetch_valid` and `setup_valid` are high and `setup_count` is non-zero, the loop is pushed at the clock edge and `loop_depth` rises by one. In that cycle `next_pc` is `fetch_pc`+1.
- R3: In count mode (`setup_mode`=0), when `fetch_pc` equals the innermost loop's end address and its remaining count is above one, `next_pc` is the loop start and the remaining count drops by one.
- R4: In count mode, when the end address is reached with a remaining count of one, `next_pc` is `fetch_pc`+1 and the loop is popped. A count of N therefore runs the body N times.
- R5: In flag mode (`setup_mode`=1), at the innermost loop's end address `next_pc` is the loop start while `loop_flag` is low. At the first end where `loop_flag` is high, `next_pc` is `fetch_pc`+1 and the loop is popped. The count value plays no part beyond the zero check of R6.
- R6: A setup with `setup_count`=0, in either mode, makes `next_pc` equal `setup_end`+1 in that cycle and pushes nothing.
- R7: Only the innermost (most recently pushed) loop's end address is compared. Outer loops resume after the inner loop is popped.
- R8: A setup with a non-zero count while all DEPTH (default 4) entries remain occupied raises `setup_reject` in that cycle and leaves the stack unchanged.
- R9: With `fetch_valid` low, no setup, wrap or pop takes effect, the stack is unchanged, and `next_pc` is `fetch_pc`+1.
- R10: When a setup and a loop end fall in the same cycle, the end decision is applied to the innermost loop first (decrement or pop), and then the new loop is pushed. The full test of R8 uses the depth after that pop. `next_pc` priority is: zero-count skip, then wrap, then `fetch_pc`+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_valid | input | 1 | A fetch happens this cycle; the stack advances only when high |
| fetch_pc | input | 16 | Address being fetched |
| setup_valid | input | 1 | The fetched word is a loop setup command |
| setup_start | input | 16 | First body address of the new loop |
| setup_end | input | 16 | Last body address of the new loop |
| setup_count | input | 16 | Iteration count; 0 skips the body |
| setup_mode | input | 1 | 0 = end on count, 1 = end on flag |
| loop_flag | input | 1 | Exit condition for flag-mode loops |
| next_pc | output | 16 | Selected next fetch address |
| setup_reject | output | 1 | Setup refused because the stack is full |
| loop_depth | output | 3 | Number of active loops |

## Verification
Two functions can meet in one cycle: a setup command placed at the end address of the active loop, and a setup at a loop end that pops a full stack. The bench provokes both by placing setup commands at loop-end addresses. It also issues a setup on the exit fetch of a four-deep stack. A behavioural model applies the end decision before the push, and its next address, reject flag and depth are compared with the design on every fetch.

// File: rtl/zol_pkg.sv
package zol_pkg;
  parameter int unsigned LOOP_AW = 16;
  parameter int unsigned LOOP_CW = 16;

  typedef enum logic {
    END_ON_COUNT = 1'b0,
    END_ON_FLAG  = 1'b1
  } loop_mode_e;

  typedef struct packed {
    logic [LOOP_AW-1:0] first_addr;
    logic [LOOP_AW-1:0] last_addr;
    logic [LOOP_CW-1:0] remain;
    loop_mode_e         mode;
  } loop_ent_t;
endpackage

// File: rtl/zol_stack.sv
module zol_stack
  import zol_pkg::*;
#(
  parameter int unsigned DEPTH = 4,
  localparam int unsigned SPW = $clog2(DEPTH + 1),
  localparam int unsigned IW  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               adv,
  input  logic               pop,
  input  logic               push,
  input  logic               upd,
  input  logic [LOOP_CW-1:0] upd_remain,
  input  loop_ent_t          push_ent,
  output loop_ent_t          top_ent,
  output logic [SPW-1:0]     depth
);
  logic [SPW-1:0] sp_q, sp_mid, sp_d;
  logic [IW-1:0]  top_idx;
  loop_ent_t      ent_q [DEPTH];

  always_comb begin
    sp_mid = pop  ? sp_q - 1'b1   : sp_q;
    sp_d   = push ? sp_mid + 1'b1 : sp_mid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   sp_q <= '0;
    else if (adv) sp_q <= sp_d;
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic      wr;
    loop_ent_t ent_d;
    always_comb begin
      wr    = 1'b0;
      ent_d = ent_q[i];
      if (push && sp_mid == SPW'(i)) begin
        wr    = 1'b1;
        ent_d = push_ent;
      end else if (upd && sp_q == SPW'(i + 1)) begin
        wr           = 1'b1;
        ent_d.remain = upd_remain;
      end
    end
    always_ff @(posedge clk) begin
      if (adv && wr) ent_q[i] <= ent_d;
    end
  end

  always_comb begin
    top_idx = IW'(sp_q - 1'b1);
    top_ent = ent_q[top_idx];
  end
  assign depth = sp_q;

  assert_pop_nonempty_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && pop) |-> (sp_q != '0));
  assert_depth_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sp_q <= SPW'(DEPTH));
  assert_push_room_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && push) |-> (sp_mid < SPW'(DEPTH)));
endmodule

// File: rtl/zol_endchk.sv
module zol_endchk
  import zol_pkg::*;
(
  input  logic               fetch_valid,
  input  logic [LOOP_AW-1:0] fetch_pc,
  input  logic               top_valid,
  input  loop_ent_t          top_ent,
  input  logic               loop_flag,
  output logic               wrap,
  output logic               leave,
  output logic               dec,
  output logic [LOOP_CW-1:0] dec_remain
);
  logic hit, done;

  always_comb begin
    hit        = fetch_valid && top_valid && (fetch_pc == top_ent.last_addr);
    done       = (top_ent.mode == END_ON_FLAG) ? loop_flag
                                               : (top_ent.remain <= LOOP_CW'(1));
    wrap       = hit && !done;
    leave      = hit && done;
    dec        = wrap && (top_ent.mode == END_ON_COUNT);
    dec_remain = top_ent.remain - 1'b1;
  end
endmodule

// File: rtl/zol_seq.sv
module zol_seq
  import zol_pkg::*;
#(
  parameter int unsigned DEPTH = 4,
  localparam int unsigned SPW = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fetch_valid,
  input  logic [LOOP_AW-1:0] fetch_pc,
  input  logic               setup_valid,
  input  logic [LOOP_AW-1:0] setup_start,
  input  logic [LOOP_AW-1:0] setup_end,
  input  logic [LOOP_CW-1:0] setup_count,
  input  logic               setup_mode,
  input  logic               loop_flag,
  output logic [LOOP_AW-1:0] next_pc,
  output logic               setup_reject,
  output logic [SPW-1:0]     loop_depth
);
  loop_ent_t          top_ent, new_ent;
  logic               wrap, leave, dec, do_push, skip, setup_live;
  logic [LOOP_CW-1:0] dec_remain;
  logic [SPW-1:0]     depth, room_depth;

  zol_endchk u_endchk (
    .fetch_valid (fetch_valid),
    .fetch_pc    (fetch_pc),
    .top_valid   (depth != '0),
    .top_ent     (top_ent),
    .loop_flag   (loop_flag),
    .wrap        (wrap),
    .leave       (leave),
    .dec         (dec),
    .dec_remain  (dec_remain)
  );

  always_comb begin
    new_ent.first_addr = setup_start;
    new_ent.last_addr  = setup_end;
    new_ent.remain     = setup_count;
    new_ent.mode       = loop_mode_e'(setup_mode);
    setup_live   = fetch_valid && setup_valid;
    skip         = setup_live && (setup_count == '0);
    room_depth   = leave ? depth - 1'b1 : depth;
    setup_reject = setup_live && !skip && (room_depth == SPW'(DEPTH));
    do_push      = setup_live && !skip && !setup_reject;
    if (skip)      next_pc = setup_end + 1'b1;
    else if (wrap) next_pc = top_ent.first_addr;
    else           next_pc = fetch_pc + 1'b1;
  end

  zol_stack #(.DEPTH(DEPTH)) u_stack (
    .clk        (clk),
    .rst_n      (rst_n),
    .adv        (fetch_valid),
    .pop        (leave),
    .push       (do_push),
    .upd        (dec),
    .upd_remain (dec_remain),
    .push_ent   (new_ent),
    .top_ent    (top_ent),
    .depth      (depth)
  );

  assign loop_depth = depth;

  assert_reject_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    setup_reject |=> (loop_depth == $past(loop_depth)));
  assert_count_dec_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !do_push) |=> (top_ent.remain == $past(top_ent.remain) - 1'b1));
  assert_skip_nopush_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (skip && !leave) |=> (loop_depth == $past(loop_depth)));
  assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_valid |=> (loop_depth == $past(loop_depth)));
endmodule

// File: tb/zol_seq_tb.sv
module zol_seq_tb;
  typedef struct { int s; int e; int c; bit m; } lp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fetch_valid = 1'b0, setup_valid = 1'b0, setup_mode = 1'b0, loop_flag = 1'b0;
  logic [15:0] fetch_pc = '0, setup_start = '0, setup_end = '0, setup_count = '0;
  logic [15:0] next_pc;
  logic        setup_reject;
  logic [2:0]  loop_depth;

  int n_chk = 0, n_fail = 0;
  lp_t stk[$];
  lp_t prog[int];

  always #5 clk = ~clk;

  zol_seq u_dut (
    .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
    .setup_valid(setup_valid), .setup_start(setup_start), .setup_end(setup_end),
    .setup_count(setup_count), .setup_mode(setup_mode), .loop_flag(loop_flag),
    .next_pc(next_pc), .setup_reject(setup_reject), .loop_depth(loop_depth)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // One fetch: drive, compare against model, advance model at the edge.
  task automatic step(input bit fv, input bit sv, input lp_t cmd, input bit flg,
                      input int pc, input string tag, output int nxt);
    bit hit, ex, wrp, skp, rej;
    @(negedge clk);
    fetch_valid = fv; setup_valid = sv; fetch_pc = 16'(pc); loop_flag = flg;
    setup_start = 16'(cmd.s); setup_end = 16'(cmd.e);
    setup_count = 16'(cmd.c); setup_mode = cmd.m;
    #1;
    hit = fv && stk.size() > 0 && pc == stk[$].e;
    ex  = (stk.size() > 0) ? (stk[$].m ? flg : (stk[$].c <= 1)) : 1'b0;
    wrp = hit && !ex;
    skp = fv && sv && cmd.c == 0;
    rej = fv && sv && cmd.c != 0 && (stk.size() - int'(hit && ex)) == 4;
    nxt = skp ? ((cmd.e + 1) & 16'hFFFF) : wrp ? stk[$].s : ((pc + 1) & 16'hFFFF);
    chk({tag, " next_pc"}, int'(next_pc), nxt);
    chk({tag, " reject"}, int'(setup_reject), int'(rej));
    chk({tag, " depth"}, int'(loop_depth), stk.size());
    @(posedge clk);
    if (hit) begin
      if (ex) void'(stk.pop_back());
      else if (!stk[$].m) stk[$].c--;
    end
    if (fv && sv && cmd.c != 0 && !rej) stk.push_back(cmd);
  endtask

  task automatic run_prog(input int start_pc, input int ncyc, input int flag_from,
                          input string tag);
    int pc = start_pc;
    int nx;
    lp_t none = '{0, 0, 0, 1'b0};
    for (int k = 0; k < ncyc; k++) begin
      if (prog.exists(pc)) step(1'b1, 1'b1, prog[pc], k >= flag_from, pc, tag, nx);
      else                 step(1'b1, 1'b0, none,     k >= flag_from, pc, tag, nx);
      pc = nx;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; fetch_valid = 1'b0; setup_valid = 1'b0;
    stk.delete(); prog.delete();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin : wdog
    #2000000;
    n_fail++; n_chk++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : main
    int nx;
    lp_t none = '{0, 0, 0, 1'b0};
    do_reset();
    // R1: reset state
    step(1'b0, 1'b0, none, 1'b0, 5, "R1", nx);

    // R2 R3 R4: single counted loop, body 11..13, three passes
    prog[10] = '{11, 13, 3, 1'b0};
    run_prog(10, 14, 999, "R2 R3 R4");

    // R7: nested counted loops
    prog[20] = '{21, 30, 2, 1'b0};
    prog[22] = '{23, 25, 3, 1'b0};
    run_prog(20, 40, 999, "R7");

    // R6: zero count skips in both modes
    prog[40] = '{41, 45, 0, 1'b0};
    prog[46] = '{47, 49, 0, 1'b1};
    run_prog(40, 4, 999, "R6");

    // R5: flag loop, flag high from the 8th fetch on
    prog[50] = '{51, 52, 9, 1'b1};
    run_prog(50, 12, 7, "R5");

    // R10: setup placed on the end address of the active loop
    prog[70] = '{71, 73, 2, 1'b0};
    prog[73] = '{74, 75, 2, 1'b0};
    run_prog(70, 20, 999, "R10");

    // R8: fifth nested setup rejected, stack kept
    do_reset();
    for (int i = 0; i < 5; i++)
      step(1'b1, 1'b1, '{300 + i, 200 + i, (i == 3) ? 1 : 4, 1'b0}, 1'b0, 60 + i, "R8", nx);
    step(1'b1, 1'b1, '{400, 401, 2, 1'b0}, 1'b0, 65, "R8", nx);
    // R9: stall at the innermost end address changes nothing
    step(1'b0, 1'b1, '{500, 501, 3, 1'b0}, 1'b0, 203, "R9", nx);
    step(1'b0, 1'b0, none, 1'b0, 203, "R9", nx);
    // R10: exit of innermost loop frees room for a setup in the same cycle
    step(1'b1, 1'b1, '{600, 610, 5, 1'b0}, 1'b0, 203, "R10", nx);
    step(1'b1, 1'b0, none, 1'b0, 610, "R10", nx);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule